// File: doc/BRIEF.md
# SPI Byte FIFO with Level Checks

This block is a byte-organised FIFO placed between a register or DMA port and an SPI shift engine. The same RTL serves the transmit or the receive side. A parameter picks the side, and that choice sets the direction in which the threshold comparisons work. Each push or pop moves one, two or four bytes, as set by a width code. Bytes travel least significant first: the low byte of a multi-byte word is the oldest byte in the queue.

Software controls the FIFO through an operation strobe that carries two bits. One bit flushes the contents and the other sets the run state. A status word reports the fill level together with full and empty flags. A byte-level threshold produces a threshold-reached flag. Three thresholds counted in 4-byte units produce urgency hints for a DMA requester.

Top module: `spi_byte_fifo`

## Requirements
- R1: After reset the FIFO is stopped and empty, and the status word reads 10'h200. Bits 7:0 hold the fill level modulo 256, bit 8 is full and bit 9 is empty.
- R2: While stopped, pushes and pops are ignored. They change no state and raise no error.
- R3: The op strobe sets the run state to op bit 1. In any op cycle, traffic on the push and pop ports is ignored.
- R4: Width code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes. Bytes enter and leave in first-in first-out order, and bits 7:0 of a word hold the oldest byte.
- R5: The pop data shows the bytes at the head without consuming them. Byte lanes beyond the current width read zero.
- R6: When 256 bytes are held, the status reads 10'h100.
- R7: A push that needs more room than is free is ignored. It raises `ovf_err` for exactly one cycle.
- R8: A pop that asks for more bytes than are held is ignored. It raises `unf_err` for exactly one cycle.
- R9: Op bit 0 empties the FIFO in the cycle it is written.
- R10: When a push and a pop happen in the same cycle, both are judged against the level before that cycle, and the level changes by their difference.
- R11: `thresh_hit` is level ≥ threshold on the receive side (IS_RX=1) and level ≤ threshold on the transmit side.
- R12: Let W be the level divided by 4. On the transmit side the hints are stop = W ≥ stop threshold, low = W ≤ low threshold and high = W ≤ high threshold. On the receive side the three comparisons are reversed: stop = W ≤ stop threshold, low = W ≥ low threshold and high = W ≥ high threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_we | input | 1 | Operation strobe |
| op_bits | input | 2 | Bit 0 flushes the FIFO, bit 1 sets the run state |
| width_sel | input | 2 | Bytes per access: 0 = 1, 1 = 2, 2 or 3 = 4 |
| thresh | input | 8 | Byte threshold |
| chk_stop | input | 6 | Stop threshold, in 4-byte units |
| chk_low | input | 6 | Low threshold, in 4-byte units |
| chk_high | input | 6 | High threshold, in 4-byte units |
| push_valid | input | 1 | Push request |
| push_data | input | 32 | Push word, oldest byte in bits 7:0 |
| pop_req | input | 1 | Pop request |
| pop_data | output | 32 | Head bytes, zeros beyond the width |
| status | output | 10 | Full, empty and level |
| thresh_hit | output | 1 | Threshold reached |
| hint_stop | output | 1 | Stop hint for the DMA requester |
| hint_low | output | 1 | Low-urgency hint |
| hint_high | output | 1 | High-urgency hint |
| ovf_err | output | 1 | One-cycle pulse on a rejected push |
| unf_err | output | 1 | One-cycle pulse on a rejected pop |

## Verification
The bench goes after the cases where a width-wide access only partly fits. A 2-byte pop with one byte held must be refused whole. A design that popped part of the word would corrupt the level and shift the scoreboard's byte order from then on. At 256 bytes the 8-bit level field wraps to zero, so a design that derived empty from that field would report a full FIFO as empty. The bench also issues a simultaneous push and pop against the pre-cycle level, runs traffic while the FIFO is stopped and during op cycles, and crosses both the threshold and the hint comparisons on a transmit and a receive instance. A design with the comparison direction reversed fails at both ends of the range.

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  parameter bit IS_RX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_we,
  input  logic [1:0]    op_bits,
  input  logic [1:0]    width_sel,
  input  logic [7:0]    thresh,
  input  logic [5:0]    chk_stop,
  input  logic [5:0]    chk_low,
  input  logic [5:0]    chk_high,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic [9:0]    status,
  output logic          thresh_hit,
  output logic          hint_stop,
  output logic          hint_low,
  output logic          hint_high,
  output logic          ovf_err,
  output logic          unf_err
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int LANES = DW / 8;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          run_q, full_q, empty_q;
  logic [CW-1:0] nb, free_b, count_nx;
  logic          traffic, push_ok, pop_ok;
  logic [CW-3:0] words;

  always_comb begin
    case (width_sel)
      2'd0:    nb = CW'(1);
      2'd1:    nb = CW'(2);
      default: nb = CW'(4);
    endcase
  end

  assign free_b   = CW'(DEPTH) - count;
  assign traffic  = run_q && !op_we;
  assign push_ok  = traffic && push_valid && (free_b >= nb);
  assign pop_ok   = traffic && pop_req && (count >= nb);
  assign count_nx = count + (push_ok ? nb : '0) - (pop_ok ? nb : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      ovf_err <= traffic && push_valid && !push_ok;
      unf_err <= traffic && pop_req && !pop_ok;
      if (op_we) begin
        run_q <= op_bits[1];
        if (op_bits[0]) begin
          wr_ptr  <= '0;
          rd_ptr  <= '0;
          count   <= '0;
          full_q  <= 1'b0;
          empty_q <= 1'b1;
        end
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + AW'(nb);
        if (pop_ok)  rd_ptr <= rd_ptr + AW'(nb);
        count   <= count_nx;
        full_q  <= (count_nx == CW'(DEPTH));
        empty_q <= (count_nx == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok)
      for (int i = 0; i < LANES; i++)
        if (CW'(i) < nb) mem[AW'(wr_ptr + AW'(i))] <= push_data[8*i +: 8];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++)
      pop_data[8*i +: 8] = (CW'(i) < nb) ? mem[AW'(rd_ptr + AW'(i))] : 8'h00;
  end

  assign status = {empty_q, full_q, count[7:0]};
  assign words  = count[CW-1:2];

  generate
    if (IS_RX) begin : g_rx
      assign thresh_hit = count >= CW'(thresh);
      assign hint_stop  = words <= (CW-2)'(chk_stop);
      assign hint_low   = words >= (CW-2)'(chk_low);
      assign hint_high  = words >= (CW-2)'(chk_high);
    end else begin : g_tx
      assign thresh_hit = count <= CW'(thresh);
      assign hint_stop  = words >= (CW-2)'(chk_stop);
      assign hint_low   = words <= (CW-2)'(chk_low);
      assign hint_high  = words <= (CW-2)'(chk_high);
    end
  endgenerate

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[8] && status[9]));
  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(push_valid) && $past(run_q));
  // R8
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |-> $past(pop_req) && $past(run_q));
  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !op_we) |=> $stable(status));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && op_bits[0]) |=> status == 10'h200);
endmodule

// File: tb/test_spi_byte_fifo.sv
module test_spi_byte_fifo;
  logic        clk = 0, rst_n = 0;
  logic        op_we = 0;
  logic [1:0]  op_bits = 0, width_sel = 0;
  logic [7:0]  thresh = 8'd128;
  logic [5:0]  chk_stop = 6'd62, chk_low = 6'd32, chk_high = 6'd2;
  logic        push_valid = 0, pop_req = 0;
  logic [31:0] push_data = 0, pop_data, pop_data_rx;
  logic [9:0]  status, status_rx;
  logic        thresh_hit, hint_stop, hint_low, hint_high, ovf_err, unf_err;
  logic        th_rx, hs_rx, hl_rx, hh_rx, ov_rx, un_rx;
  int          checks = 0, errors = 0, cyc = 0;
  logic [7:0]  expq[$];
  event        mon_ev;
  int          mon_n;
  string       mon_req;

  always #5 clk = ~clk;

  spi_byte_fifo i_spi_byte_fifo (.clk, .rst_n, .op_we, .op_bits, .width_sel, .thresh,
    .chk_stop, .chk_low, .chk_high, .push_valid, .push_data, .pop_req, .pop_data,
    .status, .thresh_hit, .hint_stop, .hint_low, .hint_high, .ovf_err, .unf_err);

  spi_byte_fifo #(.IS_RX(1'b1)) i_spi_byte_fifo_rx (.clk, .rst_n, .op_we, .op_bits,
    .width_sel, .thresh, .chk_stop(6'd2), .chk_low(6'd32), .chk_high(6'd62),
    .push_valid, .push_data, .pop_req, .pop_data(pop_data_rx), .status(status_rx),
    .thresh_hit(th_rx), .hint_stop(hs_rx), .hint_low(hl_rx), .hint_high(hh_rx),
    .ovf_err(ov_rx), .unf_err(un_rx));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  task automatic do_push(logic [1:0] w, logic [31:0] d, bit expect_ok);
    @(negedge clk);
    width_sel = w; push_data = d; push_valid = 1;
    if (expect_ok) for (int i = 0; i < nbytes(w); i++) expq.push_back(d[8*i +: 8]);
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic do_pop(logic [1:0] w, string req);
    @(negedge clk);
    width_sel = w; pop_req = 1;
    mon_n = nbytes(w); mon_req = req;
    #2 -> mon_ev;
    @(negedge clk);
    pop_req = 0;
  endtask

  task automatic do_op(logic [1:0] b);
    @(negedge clk);
    op_we = 1; op_bits = b;
    @(negedge clk);
    op_we = 0;
  endtask

  // monitor: compare head bytes against scoreboard queue
  initial forever begin
    logic [31:0] e;
    @(mon_ev);
    e = 0;
    if (expq.size() >= mon_n) begin
      for (int i = 0; i < mon_n; i++) e[8*i +: 8] = expq.pop_front();
      chk(mon_req, pop_data, e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected <20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 status", status, 10'h200);
    // R2 stopped: push ignored, no error
    do_push(0, 32'h5A, 0);
    chk("R2 no ovf", ovf_err, 0);
    chk("R2 level", status, 10'h200);
    // R3 start, traffic during op ignored
    @(negedge clk); op_we = 1; op_bits = 2'b10; push_valid = 1; push_data = 32'h77;
    @(negedge clk); op_we = 0; push_valid = 0;
    chk("R3 op-cycle push ignored", status, 10'h200);
    // R4 byte order
    do_push(0, 32'h11, 1); do_push(0, 32'h22, 1); do_push(0, 32'h33, 1);
    @(negedge clk); chk("R4 level 3", status, 10'h003);
    // R10 simultaneous push and pop
    @(negedge clk);
    width_sel = 0; push_data = 32'h44; push_valid = 1; pop_req = 1;
    mon_n = 1; mon_req = "R10 head"; expq.push_back(8'h44);
    #2 -> mon_ev;
    @(negedge clk); push_valid = 0; pop_req = 0;
    chk("R10 level", status, 10'h003);
    do_pop(0, "R4 pop"); do_pop(0, "R4 pop"); do_pop(0, "R4 pop");
    @(negedge clk); chk("R4 empty", status, 10'h200);
    do_push(1, 32'h0000BEEF, 1);
    do_push(2, 32'h01020304, 1);
    do_pop(0, "R5 byte lanes zero");
    do_pop(2, "R4 dword mix");
    chk("R4 level 1", status, 10'h001);
    // R8 partial pop refused
    do_pop(1, "R8");
    chk("R8 unf pulse", unf_err, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", unf_err, 0);
    chk("R8 level kept", status, 10'h001);
    do_pop(0, "R4 last");
    // R11 / R12 at empty
    chk("R11 tx hit at 0", thresh_hit, 1);
    chk("R11 rx hit at 0", th_rx, 0);
    chk("R12 tx hints at 0", {hint_stop, hint_low, hint_high}, 3'b011);
    chk("R12 rx hints at 0", {hs_rx, hl_rx, hh_rx}, 3'b100);
    // R6 fill
    for (int i = 0; i < 64; i++) do_push(2, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}, 1);
    chk("R6 full status", status, 10'h100);
    chk("R11 tx hit full", thresh_hit, 0);
    chk("R11 rx hit full", th_rx, 1);
    chk("R12 tx hints full", {hint_stop, hint_low, hint_high}, 3'b100);
    chk("R12 rx hints full", {hs_rx, hl_rx, hh_rx}, 3'b011);
    // R7 overflow
    do_push(0, 32'hEE, 0);
    chk("R7 ovf pulse", ovf_err, 1);
    @(negedge clk);
    chk("R7 pulse one cycle", ovf_err, 0);
    chk("R7 still full", status, 10'h100);
    for (int i = 0; i < 128; i++) do_pop(1, "R4 drain");
    chk("R4 drained", status, 10'h200);
    // R9 flush
    do_push(2, 32'hCAFEF00D, 0);
    do_op(2'b11);
    chk("R9 flushed", status, 10'h200);
    do_pop(0, "R9");
    chk("R9 nothing left", unf_err, 1);
    // R2 stop again
    do_op(2'b00);
    do_push(0, 32'h99, 0);
    chk("R2 stopped push", status, 10'h200);
    chk("R2 stopped no err", ovf_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule